// File: doc/BRIEF.md
# Host Interrupt Mask and Attention Controller

This block owns the host-facing interrupt state of a block-transfer style host/management-controller mailbox: an interrupt enable flag and an interrupt pending flag. It watches host writes to the mask register, response-ready strobes from the message path, and attention updates from the management-controller side. From these it decides when the pending flag is set or cleared. A registered, level-type interrupt line reflects the pending flag, gated by an interrupt feature switch and a global interrupt enable.

Register decode, the message buffers and the attention flags themselves live elsewhere. This block takes the current host-bound attention flag and the current SMS attention flag as inputs. It publishes the enable flag, the pending flag and the interrupt line. The mask register layout uses bit 0 for enable and bit 1 for pending, and the neighbouring decode relies on those positions.

Top module: `bt_irq_ctrl`

## Requirements
- R1: After asynchronous reset, irq_en_o, irq_pend_o and irq_o are all 0.
- R2: A mask write whose bit 0 is 1 while enable is 0 sets enable. If b2h_atn_i or sms_atn_i is 1 in that cycle, the same write also sets pending.
- R3: A mask write whose bit 0 is 0 while enable is 1 clears both enable and pending.
- R4: A mask write with bit 1 set clears pending if pending is set after the bit 0 handling of the same write. A write whose bit 0 equals the current enable leaves enable and pending untouched apart from this clear.
- R5: A response-ready strobe sets pending only when enable is 1. It has no effect when enable is 0.
- R6: An SMS update strobe whose new value equals sms_atn_i has no effect on enable or pending.
- R7: An SMS update that raises attention (current 0, new 1) sets pending only when signalling is requested, b2h_atn_i is 0 and enable is 1.
- R8: An SMS update that drops attention (current 1, new 0) clears pending when b2h_atn_i is 0. It leaves pending unchanged when b2h_atn_i is 1.
- R9: A cold reset strobe clears enable and pending. A warm reset strobe changes neither.
- R10: irq_o equals, one clock after, the AND of pending, irq_feat_i and irq_glb_en_i.
- R11: Events arriving in the same cycle are applied in this order: mask write, then response-ready, then SMS update. A cold reset overrides all of them.
- R12: Pending is never set while enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mask_wr_i | input | 1 | Host write strobe to mask register |
| mask_wdata_i | input | 2 | Write data: bit 0 enable, bit 1 clear-pending |
| rsp_ready_i | input | 1 | Response-ready event strobe |
| b2h_atn_i | input | 1 | Current host-bound attention flag |
| sms_atn_i | input | 1 | Current SMS attention flag |
| sms_upd_i | input | 1 | SMS attention update strobe |
| sms_new_i | input | 1 | New SMS attention value |
| sms_irq_req_i | input | 1 | Update requests interrupt signalling |
| cold_rst_i | input | 1 | Cold reset strobe |
| warm_rst_i | input | 1 | Warm reset strobe |
| irq_feat_i | input | 1 | Interrupt feature switch |
| irq_glb_en_i | input | 1 | Global interrupt enable |
| irq_en_o | output | 1 | Enable flag |
| irq_pend_o | output | 1 | Pending flag |
| irq_o | output | 1 | Level interrupt |

## Verification
Enable and pending change at the first rising edge after an event is presented. irq_o follows one edge later. The bench drives every stimulus on a falling edge and holds it for exactly one rising edge. It reads the flags at the next falling edge and the interrupt line at the falling edge after that, with all strobes idle in between. The bench sweeps every reachable flag state, every event type with all input combinations, and every gate setting. It compares each result against a next-state function written from the requirements.

// File: rtl/bt_irq_pkg.sv
package bt_irq_pkg;
  localparam int unsigned MASK_W   = 2;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned PEND_BIT = 1;

  typedef struct packed {
    logic en;
    logic pend;
  } mask_st_t;
endpackage

// File: rtl/bt_irq_mask_wr.sv
module bt_irq_mask_wr
  import bt_irq_pkg::*;
(
  input  mask_st_t          st_i,
  input  logic              wr_i,
  input  logic [MASK_W-1:0] wdata_i,
  input  logic              any_atn_i,
  output mask_st_t          st_o
);
  always_comb begin
    st_o = st_i;
    if (wr_i) begin
      if (wdata_i[EN_BIT] != st_i.en) begin
        if (wdata_i[EN_BIT]) begin
          if (any_atn_i) st_o.pend = 1'b1;  // retroactive raise
          st_o.en = 1'b1;
        end else begin
          st_o.pend = 1'b0;
          st_o.en   = 1'b0;
        end
      end
      if (wdata_i[PEND_BIT] && st_o.pend) st_o.pend = 1'b0;
    end
  end
endmodule

// File: rtl/bt_irq_evt.sv
module bt_irq_evt
  import bt_irq_pkg::*;
(
  input  mask_st_t st_i,
  input  logic     rsp_i,
  input  logic     b2h_atn_i,
  input  logic     sms_cur_i,
  input  logic     sms_upd_i,
  input  logic     sms_new_i,
  input  logic     sms_req_i,
  output mask_st_t st_o
);
  mask_st_t mid;

  always_comb begin
    mid = st_i;
    if (rsp_i && !st_i.pend && st_i.en) mid.pend = 1'b1;
  end

  always_comb begin
    st_o = mid;
    if (sms_upd_i && (sms_new_i != sms_cur_i)) begin
      if (sms_new_i) begin
        if (sms_req_i && !b2h_atn_i && mid.en) st_o.pend = 1'b1;
      end else if (!b2h_atn_i && mid.pend) begin
        st_o.pend = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bt_irq_line.sv
module bt_irq_line #(
  parameter bit IRQ_REG = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic feat_i,
  input  logic glb_i,
  output logic irq_o
);
  logic lvl;
  assign lvl = pend_i & feat_i & glb_i;

  generate
    if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= lvl;
      end
      assign irq_o = irq_q;

      p_irq_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pend_i |=> !irq_o);
      p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!feat_i || !glb_i) |=> !irq_o);
    end else begin : g_comb
      assign irq_o = lvl;
    end
  endgenerate
endmodule

// File: rtl/bt_irq_ctrl.sv
module bt_irq_ctrl
  import bt_irq_pkg::*;
#(
  parameter bit IRQ_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_wr_i,
  input  logic [MASK_W-1:0] mask_wdata_i,
  input  logic              rsp_ready_i,
  input  logic              b2h_atn_i,
  input  logic              sms_atn_i,
  input  logic              sms_upd_i,
  input  logic              sms_new_i,
  input  logic              sms_irq_req_i,
  input  logic              cold_rst_i,
  input  logic              warm_rst_i,
  input  logic              irq_feat_i,
  input  logic              irq_glb_en_i,
  output logic              irq_en_o,
  output logic              irq_pend_o,
  output logic              irq_o
);
  mask_st_t st_q, st_wr, st_ev, st_d;

  bt_irq_mask_wr u_mask_wr (
    .st_i      (st_q),
    .wr_i      (mask_wr_i),
    .wdata_i   (mask_wdata_i),
    .any_atn_i (b2h_atn_i | sms_atn_i),
    .st_o      (st_wr)
  );

  bt_irq_evt u_evt (
    .st_i      (st_wr),
    .rsp_i     (rsp_ready_i),
    .b2h_atn_i (b2h_atn_i),
    .sms_cur_i (sms_atn_i),
    .sms_upd_i (sms_upd_i),
    .sms_new_i (sms_new_i),
    .sms_req_i (sms_irq_req_i),
    .st_o      (st_ev)
  );

  // cold reset overrides every same-cycle event
  always_comb begin
    st_d = st_ev;
    if (cold_rst_i) st_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign irq_en_o   = st_q.en;
  assign irq_pend_o = st_q.pend;

  bt_irq_line #(.IRQ_REG(IRQ_REG)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (st_q.pend),
    .feat_i (irq_feat_i),
    .glb_i  (irq_glb_en_i),
    .irq_o  (irq_o)
  );

  p_pend_needs_en_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pend_o |-> irq_en_o);
  p_cold_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_rst_i |=> (!irq_en_o && !irq_pend_o));
  p_warm_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_rst_i && !cold_rst_i && !mask_wr_i && !rsp_ready_i && !sms_upd_i)
    |=> ($stable(irq_en_o) && $stable(irq_pend_o)));
  p_en_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && !mask_wdata_i[EN_BIT] && irq_en_o) |=> (!irq_en_o && !irq_pend_o));
  p_rsp_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_ready_i && irq_en_o && !mask_wr_i && !cold_rst_i &&
     !(sms_upd_i && !sms_new_i && sms_atn_i)) |=> irq_pend_o);
  p_sms_same_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sms_upd_i && (sms_new_i == sms_atn_i) && !mask_wr_i && !rsp_ready_i && !cold_rst_i)
    |=> ($stable(irq_en_o) && $stable(irq_pend_o)));
endmodule

// File: tb/bt_irq_ctrl_bench.sv
module bt_irq_ctrl_bench;
  localparam time CLK_PER = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, rsp = 0, b2h = 0, sms = 0, upd = 0, nv = 0, req = 0, cold = 0, warm = 0;
  logic feat = 0, glb = 0;
  logic [1:0] wd = '0;
  logic en_o, pend_o, irq_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  bt_irq_ctrl u_bt_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mask_wr_i(wr), .mask_wdata_i(wd),
    .rsp_ready_i(rsp), .b2h_atn_i(b2h), .sms_atn_i(sms), .sms_upd_i(upd),
    .sms_new_i(nv), .sms_irq_req_i(req), .cold_rst_i(cold), .warm_rst_i(warm),
    .irq_feat_i(feat), .irq_glb_en_i(glb),
    .irq_en_o(en_o), .irq_pend_o(pend_o), .irq_o(irq_o)
  );

  task automatic chk(string r, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", r, act, exp, $time);
    end
  endtask

  // next {en,pend} from the requirements
  function automatic logic [1:0] model(logic e0, logic p0, logic w, logic [1:0] d,
      logic rs, logic bh, logic sc, logic u, logic n, logic rq, logic cr);
    logic e = e0, p = p0;
    if (w) begin
      if (d[0] != e) begin
        if (d[0]) begin if (bh | sc) p = 1; e = 1; end
        else begin p = 0; e = 0; end
      end
      if (d[1] && p) p = 0;
    end
    if (rs && !p && e) p = 1;
    if (u && n != sc) begin
      if (n) begin if (rq && !bh && e) p = 1; end
      else if (!bh && p) p = 0;
    end
    if (cr) begin e = 0; p = 0; end
    return {e, p};
  endfunction

  task automatic idle();
    wr = 0; wd = '0; rsp = 0; b2h = 0; sms = 0; upd = 0; nv = 0; req = 0;
    cold = 0; warm = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  // 0:(0,0) 1:(1,0) 2:(1,1)
  task automatic set_state(int s);
    @(negedge clk); idle(); cold = 1; step();
    if (s >= 1) begin wr = 1; wd = 2'b01; step(); end
    if (s == 2) begin rsp = 1; step(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] ex;
    idle();
    #(CLK_PER*2); @(negedge clk);
    chk("R1", {en_o, pend_o}, 2'b00); chk("R1", {1'b0, irq_o}, 2'b00);
    rst_n = 1;
    for (int g = 0; g < 4; g++) begin
      feat = g[0]; glb = g[1];
      for (int s = 0; s < 3; s++) begin
        for (int k = 0; k < 4; k++) begin
          for (int c = 0; c < 16; c++) begin
            logic se, sp;
            string r;
            if ((k == 1 && c > 0) || (k == 3 && c > 1)) continue;
            set_state(s);
            se = (s >= 1); sp = (s == 2);
            chk("R2", {en_o, pend_o}, {se, sp});
            case (k)
              0: begin
                wr = 1; wd = c[1:0]; b2h = c[2]; sms = c[3];
                r = (c[0] && !se) ? "R2" : (!c[0] && se) ? "R3" : "R4";
              end
              1: begin rsp = 1; r = "R5"; end
              2: begin
                sms = c[0]; nv = c[1]; req = c[2]; b2h = c[3]; upd = 1;
                r = (c[0] == c[1]) ? "R6" : c[1] ? "R7" : "R8";
              end
              default: begin
                if (c[0]) begin cold = 1; r = "R9"; end
                else begin warm = 1; r = "R9"; end
              end
            endcase
            ex = model(se, sp, wr, wd, rsp, b2h, sms, upd, nv, req, cold);
            step();
            chk(r, {en_o, pend_o}, ex);
            chk("R12", {1'b0, pend_o & ~en_o}, 2'b00);
            @(posedge clk); @(negedge clk);
            chk("R10", {1'b0, irq_o}, {1'b0, ex[0] & feat & glb});
          end
        end
      end
    end
    feat = 1; glb = 1;
    // R11: write before response in same cycle
    set_state(0); wr = 1; wd = 2'b01; rsp = 1; step();
    chk("R11", {en_o, pend_o}, 2'b11);
    // R11: write clear-pending applied before response re-sets it
    set_state(2); wr = 1; wd = 2'b11; rsp = 1; step();
    chk("R11", {en_o, pend_o}, 2'b11);
    // R11: response then sms drop clears it
    set_state(1); rsp = 1; upd = 1; sms = 1; nv = 0; step();
    chk("R11", {en_o, pend_o}, 2'b10);
    // R11: cold overrides everything
    set_state(0); cold = 1; wr = 1; wd = 2'b01; rsp = 1; b2h = 1; step();
    chk("R11", {en_o, pend_o}, 2'b00);
    @(posedge clk); @(negedge clk);
    chk("R10", {1'b0, irq_o}, 2'b00);
    // R10: gate drop follows one cycle later
    set_state(2); @(posedge clk); @(negedge clk);
    chk("R10", {1'b0, irq_o}, 2'b01);
    glb = 0; @(posedge clk); @(negedge clk);
    chk("R10", {1'b0, irq_o}, 2'b00);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule